// File: doc/BRIEF.md
# Low-Power Wait Controller

This block sequences the only low-power state of a small 8-bit core. The instruction stage presents a decoded opcode with a valid strobe. A wait opcode parks the core: the CPU clock enable drops and the interrupt-mask bit is cleared, so any interrupt that is pending can wake the core. The oscillator enable and the peripheral clock enable never drop. Peripheral bus masters therefore keep working while the core sleeps. When an interrupt is pending during wait, the core gets a one-cycle vector-fetch slot that selects the interrupt vector, with the mask bit set for the service routine. When the saved condition register is popped later, the datapath writes the mask bit back through the mask-write port.

A halt opcode would stop the oscillator, so this block treats it as illegal. It raises an internal reset instead. Every reset cause goes through one stabilisation window of 2^DLY_W cycles (4096 by default), counted on the free-running clock. These causes are the block reset, the external reset request and the illegal halt. After the window comes a vector-fetch slot that selects the reset vector. All outputs are registered.

Top module: `lpw_ctrl`

## Requirements
- R1: `cpu_clk_en` is 1 in the run state and in the vector-fetch slot. It is 0 in the wait state and throughout the reset window.
- R2: `osc_en` and `periph_clk_en` are 1 on every cycle after the first reset edge, wait included, so peripheral bus masters are never stalled.
- R3: A wait opcode (`instr_valid`=1, `instr_op`=OP_WAIT, default 8'hA1) sampled in run moves the block to wait on the next edge with `imask`=0. In the same cycle it overrides a mask write.
- R4: In wait, `irq_pending`=1 gives on the next edge a single vector-fetch cycle with `vec_fetch`=1, `vec_sel`=0 (interrupt vector) and `imask`=1. The block then returns to run.
- R5: A wait opcode sampled while `irq_pending` is already 1 spends exactly one cycle in wait before the interrupt vector-fetch cycle.
- R6: A halt opcode (`instr_op`=OP_HALT, default 8'hA2) sampled in run raises `core_rst` on the next edge. The oscillator enable stays 1.
- R7: After the last reset cause, `core_rst` stays 1 for exactly 2^DLY_W cycles with `imask`=1. Then follows one cycle with `vec_fetch`=1 and `vec_sel`=1 (reset vector), then run. `vec_sel` is 0 whenever `vec_fetch` is 0.
- R8: `ext_rst_req` takes priority over a pending interrupt in the same cycle. When it arrives during the reset window, the window restarts from its full length.
- R9: `mask_wr_en` loads `mask_wr_val` into `imask` only in run. Outside run, mask writes and instruction strobes change nothing.
- R10: While `rst` is high, every edge leaves `core_rst`=1, `imask`=1, `cpu_clk_en`=0 and `vec_fetch`=0. The reset window is then counted from the last such edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst | input | 1 | Synchronous active-high block reset |
| ext_rst_req | input | 1 | External reset request |
| instr_valid | input | 1 | Opcode strobe from the instruction stage |
| instr_op | input | OP_W | Opcode under decode |
| irq_pending | input | 1 | An enabled interrupt is pending |
| mask_wr_en | input | 1 | Datapath write of the mask bit (condition-register pop) |
| mask_wr_val | input | 1 | Value for the mask bit |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_en | output | 1 | Oscillator enable, always on |
| periph_clk_en | output | 1 | Peripheral clock enable, always on |
| imask | output | 1 | Interrupt-mask bit |
| vec_fetch | output | 1 | Vector-fetch slot for the fetch unit |
| vec_sel | output | 1 | 1 selects the reset vector, 0 selects the interrupt vector |
| core_rst | output | 1 | Internal reset request to the core |

## Verification
Three pairs of events can land in the same cycle. An external reset can meet a wake-up interrupt, a wait opcode can meet an interrupt that is already pending, and a wait opcode can meet a mask write. The bench drives each pair on one edge. It then judges which event won from the clock enable, the reset request, the vector select and the mask bit on the following cycles. A behavioural model compares all outputs on every clock. A reset request is also injected part-way through the stabilisation window, and the bench counts the full window again from that point.

// File: rtl/lpw_pkg.sv
package lpw_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_WAIT   = 2'd1,
    ST_RDLY   = 2'd2,
    ST_VFETCH = 2'd3
  } lpw_state_e;

  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_WAIT = 2'd1,
    REQ_HALT = 2'd2
  } lpw_req_e;

  typedef struct packed {
    lpw_state_e state;
    logic       imask;
    logic       vsel;
  } lpw_ctx_s;

endpackage

// File: rtl/lpw_decode.sv
module lpw_decode #(
  parameter int unsigned      OP_W    = 8,
  parameter logic [OP_W-1:0]  OP_WAIT = 8'hA1,
  parameter logic [OP_W-1:0]  OP_HALT = 8'hA2
) (
  input  logic               instr_valid,
  input  logic [OP_W-1:0]    instr_op,
  input  logic               run_i,
  output lpw_pkg::lpw_req_e  req_o
);
  import lpw_pkg::*;

  // Opcodes count only while the core is actually executing.
  always_comb begin
    req_o = REQ_NONE;
    if (instr_valid && run_i) begin
      if (instr_op == OP_WAIT)      req_o = REQ_WAIT;
      else if (instr_op == OP_HALT) req_o = REQ_HALT;
    end
  end
endmodule

// File: rtl/lpw_delay.sv
module lpw_delay #(
  parameter int unsigned DLY_W = 12
) (
  input  logic clk,
  input  logic clr_i,
  input  logic en_i,
  output logic done_o
);
  localparam logic [DLY_W-1:0] LAST = '1;

  logic [DLY_W-1:0] cnt_q;

  // Restart on any reset cause; idle at zero outside the window.
  always_ff @(posedge clk) begin
    if (clr_i || !en_i) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = en_i && !clr_i && (cnt_q == LAST);
endmodule

// File: rtl/lpw_fsm.sv
module lpw_fsm (
  input  logic               clk,
  input  logic               rst,
  input  logic               ext_rst_req,
  input  lpw_pkg::lpw_req_e  req_i,
  input  logic               irq_pending,
  input  logic               mask_wr_en,
  input  logic               mask_wr_val,
  input  logic               dly_done_i,
  output logic               run_o,
  output logic               dly_en_o,
  output logic               dly_clr_o,
  output lpw_pkg::lpw_ctx_s  ctx_n_o
);
  import lpw_pkg::*;

  lpw_ctx_s ctx_q;
  lpw_ctx_s ctx_n;
  logic     rst_cause;

  assign run_o     = (ctx_q.state == ST_RUN);
  assign dly_en_o  = (ctx_q.state == ST_RDLY);
  assign rst_cause = rst || ext_rst_req || (req_i == REQ_HALT);
  assign dly_clr_o = rst_cause;

  always_comb begin
    ctx_n = ctx_q;
    if (rst_cause) begin
      ctx_n.state = ST_RDLY;
      ctx_n.imask = 1'b1;
      ctx_n.vsel  = 1'b0;
    end else begin
      unique case (ctx_q.state)
        ST_RUN: begin
          if (req_i == REQ_WAIT) begin
            ctx_n.state = ST_WAIT;
            ctx_n.imask = 1'b0;
          end else if (mask_wr_en) begin
            ctx_n.imask = mask_wr_val;
          end
        end
        ST_WAIT: begin
          if (irq_pending) begin
            ctx_n.state = ST_VFETCH;
            ctx_n.imask = 1'b1;
            ctx_n.vsel  = 1'b0;
          end
        end
        ST_RDLY: begin
          if (dly_done_i) begin
            ctx_n.state = ST_VFETCH;
            ctx_n.vsel  = 1'b1;
          end
        end
        ST_VFETCH: begin
          ctx_n.state = ST_RUN;
          ctx_n.vsel  = 1'b0;
        end
        default: ctx_n.state = ST_RDLY;
      endcase
    end
  end

  always_ff @(posedge clk) ctx_q <= ctx_n;

  assign ctx_n_o = ctx_n;
endmodule

// File: rtl/lpw_ctrl.sv
module lpw_ctrl #(
  parameter int unsigned      OP_W    = 8,
  parameter logic [OP_W-1:0]  OP_WAIT = 8'hA1,
  parameter logic [OP_W-1:0]  OP_HALT = 8'hA2,
  parameter int unsigned      DLY_W   = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ext_rst_req,
  input  logic            instr_valid,
  input  logic [OP_W-1:0] instr_op,
  input  logic            irq_pending,
  input  logic            mask_wr_en,
  input  logic            mask_wr_val,
  output logic            cpu_clk_en,
  output logic            osc_en,
  output logic            periph_clk_en,
  output logic            imask,
  output logic            vec_fetch,
  output logic            vec_sel,
  output logic            core_rst
);
  import lpw_pkg::*;

  lpw_req_e req;
  lpw_ctx_s ctx_n;
  logic     run, dly_en, dly_clr, dly_done;

  lpw_decode #(.OP_W(OP_W), .OP_WAIT(OP_WAIT), .OP_HALT(OP_HALT)) u_dec (
    .instr_valid (instr_valid),
    .instr_op    (instr_op),
    .run_i       (run),
    .req_o       (req)
  );

  lpw_delay #(.DLY_W(DLY_W)) u_dly (
    .clk    (clk),
    .clr_i  (dly_clr),
    .en_i   (dly_en),
    .done_o (dly_done)
  );

  lpw_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .ext_rst_req (ext_rst_req),
    .req_i       (req),
    .irq_pending (irq_pending),
    .mask_wr_en  (mask_wr_en),
    .mask_wr_val (mask_wr_val),
    .dly_done_i  (dly_done),
    .run_o       (run),
    .dly_en_o    (dly_en),
    .dly_clr_o   (dly_clr),
    .ctx_n_o     (ctx_n)
  );

  // Output stage registered from next-state so it lines up with the state flops.
  always_ff @(posedge clk) begin
    cpu_clk_en    <= (ctx_n.state == ST_RUN) || (ctx_n.state == ST_VFETCH);
    core_rst      <= (ctx_n.state == ST_RDLY);
    vec_fetch     <= (ctx_n.state == ST_VFETCH);
    vec_sel       <= (ctx_n.state == ST_VFETCH) && ctx_n.vsel;
    imask         <= ctx_n.imask;
    osc_en        <= 1'b1;
    periph_clk_en <= 1'b1;
  end
endmodule

// File: rtl/lpw_ctrl_chk.sv
module lpw_ctrl_chk #(
  parameter int unsigned      OP_W    = 8,
  parameter logic [OP_W-1:0]  OP_WAIT = 8'hA1,
  parameter logic [OP_W-1:0]  OP_HALT = 8'hA2,
  parameter int unsigned      DLY_W   = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            ext_rst_req,
  input logic            instr_valid,
  input logic [OP_W-1:0] instr_op,
  input logic            irq_pending,
  input logic            cpu_clk_en,
  input logic            osc_en,
  input logic            imask,
  input logic            vec_fetch,
  input logic            vec_sel,
  input logic            core_rst
);
  localparam logic [DLY_W:0] WIN = (DLY_W+1)'(1) << DLY_W;

  logic [DLY_W:0] win_len;
  logic           in_run, in_wait;

  assign in_run  = cpu_clk_en && !vec_fetch;
  assign in_wait = !cpu_clk_en && !core_rst;

  always_ff @(posedge clk) begin
    if (rst || ext_rst_req) win_len <= '0;
    else if (core_rst)      win_len <= win_len + 1'b1;
    else                    win_len <= '0;
  end

  p_wait_entry_r3: assert property (@(posedge clk) disable iff (rst)
    (in_run && instr_valid && instr_op == OP_WAIT && !ext_rst_req)
      |=> (!cpu_clk_en && !core_rst && !imask));

  p_wake_r4: assert property (@(posedge clk) disable iff (rst)
    (in_wait && irq_pending && !ext_rst_req) |=> (vec_fetch && !vec_sel && imask));

  p_vf_single_r4: assert property (@(posedge clk) disable iff (rst)
    vec_fetch |=> !vec_fetch);

  p_halt_rst_r6: assert property (@(posedge clk) disable iff (rst)
    (in_run && instr_valid && instr_op == OP_HALT) |=> (core_rst && osc_en));

  p_win_len_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(core_rst) |-> (win_len == WIN && vec_fetch && vec_sel));

  p_rst_mask_r7: assert property (@(posedge clk) disable iff (rst)
    core_rst |-> imask);

  p_ext_prio_r8: assert property (@(posedge clk) disable iff (rst)
    ext_rst_req |=> (core_rst && !vec_fetch));

  p_wait_mask_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (in_wait && !irq_pending && !ext_rst_req) |=> $stable(imask));
endmodule

bind lpw_ctrl lpw_ctrl_chk #(
  .OP_W(OP_W), .OP_WAIT(OP_WAIT), .OP_HALT(OP_HALT), .DLY_W(DLY_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ext_rst_req (ext_rst_req),
  .instr_valid (instr_valid),
  .instr_op    (instr_op),
  .irq_pending (irq_pending),
  .cpu_clk_en  (cpu_clk_en),
  .osc_en      (osc_en),
  .imask       (imask),
  .vec_fetch   (vec_fetch),
  .vec_sel     (vec_sel),
  .core_rst    (core_rst)
);

// File: tb/lpw_ctrl_tb.sv
module lpw_ctrl_tb;
  localparam int DLY_W = 12;
  localparam int WIN   = 1 << DLY_W;
  localparam logic [7:0] OPW = 8'hA1;
  localparam logic [7:0] OPH = 8'hA2;

  logic clk = 1'b0;
  logic rst = 1'b1, ext_rst_req = 1'b0, instr_valid = 1'b0, irq_pending = 1'b0;
  logic mask_wr_en = 1'b0, mask_wr_val = 1'b0;
  logic [7:0] instr_op = 8'h00;
  logic cpu_clk_en, osc_en, periph_clk_en, imask, vec_fetch, vec_sel, core_rst;

  always #4 clk = ~clk;

  lpw_ctrl #(.OP_W(8), .OP_WAIT(OPW), .OP_HALT(OPH), .DLY_W(DLY_W)) u_dut (
    .clk(clk), .rst(rst), .ext_rst_req(ext_rst_req), .instr_valid(instr_valid),
    .instr_op(instr_op), .irq_pending(irq_pending), .mask_wr_en(mask_wr_en),
    .mask_wr_val(mask_wr_val), .cpu_clk_en(cpu_clk_en), .osc_en(osc_en),
    .periph_clk_en(periph_clk_en), .imask(imask), .vec_fetch(vec_fetch),
    .vec_sel(vec_sel), .core_rst(core_rst)
  );

  int errors = 0, checks = 0, cycles = 0;
  bit finished = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: 0 run, 1 wait, 2 reset window, 3 vector slot
  int m_st = 2, m_cnt = 0, m_vs = 0;
  bit m_mask = 1, m_live = 0;

  always @(posedge clk) begin
    if (rst || ext_rst_req) begin
      m_st = 2; m_cnt = 0; m_mask = 1; m_vs = 0; if (rst) m_live = 1;
    end else if (m_st == 0) begin
      if (instr_valid && instr_op == OPH) begin m_st = 2; m_cnt = 0; m_mask = 1; end
      else if (instr_valid && instr_op == OPW) begin m_st = 1; m_mask = 0; end
      else if (mask_wr_en) m_mask = mask_wr_val;
    end else if (m_st == 1) begin
      if (irq_pending) begin m_st = 3; m_vs = 0; m_mask = 1; end
    end else if (m_st == 2) begin
      if (m_cnt == WIN - 1) begin m_st = 3; m_vs = 1; end
      else m_cnt++;
    end else begin
      m_st = 0;
    end
  end

  always @(negedge clk) begin
    if (m_live && !finished) begin
      chk("R1", "cpu_clk_en", cpu_clk_en, (m_st == 0 || m_st == 3));
      chk("R2", "osc_en/periph_clk_en", {osc_en, periph_clk_en}, 3);
      chk("R7", "core_rst", core_rst, m_st == 2);
      chk("R4", "vec_fetch", vec_fetch, m_st == 3);
      chk("R7", "vec_sel", vec_sel, (m_st == 3) && (m_vs == 1));
      chk("R9", "imask", imask, m_mask);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic cyc(input bit r, input bit er, input bit iv, input logic [7:0] op,
                     input bit irq, input bit mw, input bit mv);
    rst = r; ext_rst_req = er; instr_valid = iv; instr_op = op;
    irq_pending = irq; mask_wr_en = mw; mask_wr_val = mv;
    @(negedge clk);
  endtask

  task automatic idle(); cyc(0, 0, 0, 8'h00, 0, 0, 0); endtask

  // Count window cycles still to go (including the current one) until the vector slot.
  task automatic run_window(input string tag, input int already);
    int n;
    n = already;
    for (int i = 0; i < WIN + 8; i++) begin
      idle();
      if (core_rst) n++;
      else break;
    end
    chk(tag, "window length", n, WIN);
    chk(tag, "reset vector slot", {vec_fetch, vec_sel}, 3);
    idle();
    chk(tag, "back to run", {cpu_clk_en, vec_fetch}, 2);
  endtask

  initial begin
    @(negedge clk);
    cyc(1, 0, 1, OPW, 1, 1, 0);
    cyc(1, 0, 0, 8'h00, 0, 0, 0);
    cyc(1, 0, 0, 8'h00, 0, 0, 0);
    chk("R10", "reset state", {core_rst, imask, cpu_clk_en, vec_fetch}, 4'b1100);
    run_window("R7", 1);

    // R9: mask write in run
    cyc(0, 0, 0, 8'h00, 0, 1, 0);
    chk("R9", "mask write 0", imask, 0);
    cyc(0, 0, 0, 8'h00, 0, 1, 1);
    chk("R9", "mask write 1", imask, 1);

    // R3: wait beats a same-cycle mask write
    cyc(0, 0, 1, OPW, 0, 1, 1);
    chk("R3", "enter wait", {cpu_clk_en, core_rst, imask}, 0);
    // R9: writes and opcodes ignored in wait
    for (int i = 0; i < 5; i++) begin
      cyc(0, 0, 1, OPH, 0, 1, 1);
      chk("R9", "wait ignores strobes", {cpu_clk_en, core_rst, imask}, 0);
    end
    // R4: interrupt wakes
    cyc(0, 0, 0, 8'h00, 1, 0, 0);
    chk("R4", "irq vector slot", {vec_fetch, vec_sel, imask}, 3'b101);
    idle();
    chk("R4", "resume run", {cpu_clk_en, vec_fetch}, 2);

    // R5: wait with an interrupt already pending
    cyc(0, 0, 0, 8'h00, 0, 1, 0);
    cyc(0, 0, 1, OPW, 1, 0, 0);
    chk("R5", "one wait cycle", {cpu_clk_en, vec_fetch}, 0);
    cyc(0, 0, 0, 8'h00, 1, 0, 0);
    chk("R5", "then irq slot", {vec_fetch, vec_sel}, 2);
    idle();

    // R6: illegal halt resets through the window
    cyc(0, 0, 1, OPH, 0, 0, 0);
    chk("R6", "halt raises reset", {core_rst, osc_en, periph_clk_en, cpu_clk_en}, 4'b1110);
    for (int i = 0; i < 99; i++) idle();
    // R8: reset request restarts the window
    cyc(0, 1, 0, 8'h00, 0, 0, 0);
    chk("R8", "restart keeps reset", core_rst, 1);
    run_window("R8", 1);

    // R8: reset beats interrupt in wait
    cyc(0, 0, 1, OPW, 0, 0, 0);
    cyc(0, 1, 0, 8'h00, 1, 0, 0);
    chk("R8", "reset over irq", {core_rst, vec_fetch, imask}, 3'b101);
    run_window("R6", 1);

    idle();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule